// File: doc/BRIEF.md
# Minimum-Energy Supply Controller with Idle Power Gating

This block sets the supply code for a target circuit that uses both voltage/frequency scaling and power gating. The delay monitor requests a supply code. The block never lets the regulator go below a measured minimum-energy code. While the supply sits at that floor, the block may switch the target off whenever the target reports that it is idle.

To find the floor, the block drives the three analog switches of an optimal-voltage determiner. For each candidate code it runs three phases: a precharge, a charge phase timed by the critical-path delay at the candidate, and a discharge phase timed by the delay one step lower. It then reads the determiner's comparator. The candidate starts at the present regulator code and moves down one 20 mV step per measurement. The first candidate at which the comparator reports the capacitor at or below its threshold becomes the optimum. The target keeps running throughout a search. Asserting the restart input runs the search again, so the optimum can follow temperature drift.

A wake-up count hides the output of a freshly powered-on target from downstream logic.

Top module: `mep_supply_ctrl`

## Requirements
- R1: A `restart` pulse while `searching` is low starts a search whose first candidate equals the current `reg_code`. A `restart` while `searching` is high has no effect on the result or on the phase timing.
- R2: Each measurement raises `sw_pre` for PRE_CYC cycles, then `sw_chg`, then `sw_dis`. At most one switch is high in any cycle, and exactly one cycle with all three low separates consecutive phases.
- R3: `sw_chg` stays high for max(`t1_len`,1) cycles and `sw_dis` for max(`t2_len`,1) cycles in every measurement.
- R4: `cmp_low` (1 = capacitor at or below threshold) is sampled in the cycle after the gap that follows discharge. If it is 1, `cand_code` is latched into `opt_code`, `opt_valid` goes high and `searching` drops.
- R5: If `cmp_low` is 0, the candidate decreases by one code and a new measurement starts. At code 0 with `cmp_low` 0, the optimum becomes 0.
- R6: One clock after its inputs change, `reg_code` equals max(`dm_code`, `opt_code`) while `opt_valid` is 1, and `dm_code` before the first search completes.
- R7: Gating is enabled only when `opt_valid` is 1 and `reg_code` equals `opt_code`. While enabled, `pwr_off` rises one clock after `idle` is first sampled high. Otherwise it stays low.
- R8: `pwr_off` falls in the same cycle that `idle` falls. `out_valid` then stays low until `wake_len` cycles after the first clock edge that samples `idle` low.
- R9: `reg_code` keeps following `dm_code` while a search is in progress.
- R10: After reset, all switches, `searching`, `opt_valid`, `opt_code`, `reg_code` and `pwr_off` are 0 and `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Starts an optimum search |
| dm_code | input | CODE_W | Delay-monitor supply request, 20 mV per LSB |
| t1_len | input | LEN_W | Charge-phase length in cycles |
| t2_len | input | LEN_W | Discharge-phase length in cycles |
| cmp_low | input | 1 | Determiner comparator, 1 = at or below threshold |
| idle | input | 1 | Target reports no work |
| wake_len | input | WAKE_W | Cycles `out_valid` stays low after wake-up |
| sw_pre | output | 1 | Precharge switch enable |
| sw_chg | output | 1 | Charge switch enable |
| sw_dis | output | 1 | Discharge switch enable |
| cand_code | output | CODE_W | Candidate supply under measurement |
| searching | output | 1 | Search in progress |
| opt_code | output | CODE_W | Latched minimum-energy code |
| opt_valid | output | 1 | A search has completed |
| reg_code | output | CODE_W | Regulator supply code |
| pwr_off | output | 1 | Target power switch off |
| out_valid | output | 1 | Target output usable |

## Verification
The assertions assume that `cmp_low`, `t1_len` and `t2_len` stay constant within one measurement. They also assume that `dm_code` and `idle` are never unknown once reset is released. The bench drives every input from reset onward. It changes the phase lengths only between searches. It derives `cmp_low` from `cand_code` through a fixed comparator model, so the comparator only changes when the candidate does. Mid-search changes are limited to `dm_code` and a repeated `restart`. The requirements state that both are tolerated.

// File: rtl/mep_pkg.sv
package mep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_GAP1,
      ST_CHG,
      ST_GAP2,
      ST_DIS,
      ST_GAP3,
      ST_CMP
   } mep_st_e;

endpackage

// File: rtl/mep_search.sv
module mep_search
   import mep_pkg::*;
#(
   parameter int CODE_W  = 6,
   parameter int LEN_W   = 4,
   parameter int PRE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] start_code,
   input  logic [LEN_W-1:0]  t1_len,
   input  logic [LEN_W-1:0]  t2_len,
   input  logic              cmp_low,
   output logic              sw_pre,
   output logic              sw_chg,
   output logic              sw_dis,
   output logic [CODE_W-1:0] cand_code,
   output logic              searching,
   output logic [CODE_W-1:0] opt_code,
   output logic              opt_valid
);

   localparam int PRE_W = $clog2(PRE_CYC + 1);
   localparam int CNT_W = (PRE_W > LEN_W) ? PRE_W : LEN_W;
   localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_CYC - 1);

   mep_st_e          st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] t1_load;
   logic [CNT_W-1:0] t2_load;
   logic             pre_last;
   logic             cnt_zero;

   assign cnt_zero = (cnt == '0);

   generate
      if (PRE_CYC == 1) begin : g_pre_single
         assign pre_last = 1'b1;
      end else begin : g_pre_multi
         assign pre_last = cnt_zero;
      end
   endgenerate

   always_comb begin
      t1_load = (t1_len == '0) ? '0 : CNT_W'(t1_len - 1'b1);
      t2_load = (t2_len == '0) ? '0 : CNT_W'(t2_len - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         cand_code <= '0;
         opt_code  <= '0;
         opt_valid <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (restart) begin
                  cand_code <= start_code;
                  cnt       <= PRE_LOAD;
                  st        <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (pre_last) st <= ST_GAP1;
               else          cnt <= cnt - 1'b1;
            end
            ST_GAP1: begin
               cnt <= t1_load;
               st  <= ST_CHG;
            end
            ST_CHG: begin
               if (cnt_zero) st <= ST_GAP2;
               else          cnt <= cnt - 1'b1;
            end
            ST_GAP2: begin
               cnt <= t2_load;
               st  <= ST_DIS;
            end
            ST_DIS: begin
               if (cnt_zero) st <= ST_GAP3;
               else          cnt <= cnt - 1'b1;
            end
            ST_GAP3: st <= ST_CMP;
            ST_CMP: begin
               if (cmp_low || cand_code == '0) begin
                  opt_code  <= cand_code;
                  opt_valid <= 1'b1;
                  st        <= ST_IDLE;
               end else begin
                  cand_code <= cand_code - 1'b1;
                  cnt       <= PRE_LOAD;
                  st        <= ST_PRE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sw_pre    = (st == ST_PRE);
   assign sw_chg    = (st == ST_CHG);
   assign sw_dis    = (st == ST_DIS);
   assign searching = (st != ST_IDLE);

   // R2: a phase that ends is followed by one quiet cycle and then the next phase
   a_r2_pre_then_chg: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_pre) |=> sw_chg);
   a_r2_chg_then_dis: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_chg) |=> sw_dis);
   a_r2_gap_before_on: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sw_pre) || $rose(sw_chg) || $rose(sw_dis)) |->
      $past(!sw_pre && !sw_chg && !sw_dis));
   // R5: a new measurement inside a search uses the next lower code
   a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sw_pre) && $past(searching)) |-> cand_code == $past(cand_code) - 1'b1);
   // R4: the end of a search latches the candidate that was measured
   a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(searching) && !searching) |-> (opt_valid && opt_code == $past(cand_code)));

endmodule

// File: rtl/mep_clamp.sv
module mep_clamp #(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] dm_code,
   input  logic [CODE_W-1:0] opt_code,
   input  logic              opt_valid,
   output logic [CODE_W-1:0] reg_code
);

   logic [CODE_W-1:0] floor_code;
   logic [CODE_W-1:0] next_code;

   always_comb begin
      floor_code = opt_valid ? opt_code : '0;
      next_code  = (dm_code > floor_code) ? dm_code : floor_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_code <= '0;
      else        reg_code <= next_code;
   end

   // R6: never below the optimum once known, never below the request
   a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
      $past(opt_valid) |-> reg_code >= $past(opt_code));
   a_r6_request: assert property (@(posedge clk) disable iff (!rst_n)
      reg_code >= $past(dm_code));

endmodule

// File: rtl/mep_gate.sv
module mep_gate #(
   parameter int CODE_W = 6,
   parameter int WAKE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   input  logic [CODE_W-1:0] reg_code,
   input  logic [CODE_W-1:0] opt_code,
   input  logic              opt_valid,
   input  logic [WAKE_W-1:0] wake_len,
   output logic              pwr_off,
   output logic              out_valid
);

   logic              gate_en;
   logic              off_q;
   logic [WAKE_W-1:0] wake_cnt;

   assign gate_en = opt_valid && (reg_code == opt_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q    <= 1'b0;
         wake_cnt <= '0;
      end else begin
         off_q <= gate_en && idle;
         if (off_q && !idle)       wake_cnt <= wake_len;
         else if (wake_cnt != '0)  wake_cnt <= wake_cnt - 1'b1;
      end
   end

   assign pwr_off   = off_q && idle;
   assign out_valid = !off_q && (wake_cnt == '0);

   // R7: the switch is only opened when the previous cycle sat at the optimum
   a_r7_only_at_opt: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_off |-> $past(opt_valid && reg_code == opt_code));
   // R8: output is never marked usable at the moment power returns
   a_r8_wake_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_off) |-> !out_valid);

endmodule

// File: rtl/mep_supply_ctrl.sv
module mep_supply_ctrl #(
   parameter int CODE_W  = 6,
   parameter int LEN_W   = 4,
   parameter int WAKE_W  = 4,
   parameter int PRE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] dm_code,
   input  logic [LEN_W-1:0]  t1_len,
   input  logic [LEN_W-1:0]  t2_len,
   input  logic              cmp_low,
   input  logic              idle,
   input  logic [WAKE_W-1:0] wake_len,
   output logic              sw_pre,
   output logic              sw_chg,
   output logic              sw_dis,
   output logic [CODE_W-1:0] cand_code,
   output logic              searching,
   output logic [CODE_W-1:0] opt_code,
   output logic              opt_valid,
   output logic [CODE_W-1:0] reg_code,
   output logic              pwr_off,
   output logic              out_valid
);

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code
         $error("CODE_W out of range");
      end
      if (LEN_W < 1 || WAKE_W < 1) begin : g_bad_len
         $error("LEN_W and WAKE_W must be positive");
      end
      if (PRE_CYC < 1) begin : g_bad_pre
         $error("PRE_CYC must be at least one");
      end
   endgenerate

   mep_search #(
      .CODE_W (CODE_W),
      .LEN_W  (LEN_W),
      .PRE_CYC(PRE_CYC)
   ) u_search (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .start_code(reg_code),
      .t1_len    (t1_len),
      .t2_len    (t2_len),
      .cmp_low   (cmp_low),
      .sw_pre    (sw_pre),
      .sw_chg    (sw_chg),
      .sw_dis    (sw_dis),
      .cand_code (cand_code),
      .searching (searching),
      .opt_code  (opt_code),
      .opt_valid (opt_valid)
   );

   mep_clamp #(
      .CODE_W(CODE_W)
   ) u_clamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .dm_code  (dm_code),
      .opt_code (opt_code),
      .opt_valid(opt_valid),
      .reg_code (reg_code)
   );

   mep_gate #(
      .CODE_W(CODE_W),
      .WAKE_W(WAKE_W)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle),
      .reg_code (reg_code),
      .opt_code (opt_code),
      .opt_valid(opt_valid),
      .wake_len (wake_len),
      .pwr_off  (pwr_off),
      .out_valid(out_valid)
   );

endmodule

// File: tb/mep_supply_ctrl_bench.sv
`timescale 1ns/1ps
module mep_supply_ctrl_bench;

   localparam int CW = 6;
   localparam int LW = 4;
   localparam int WW = 4;
   localparam int PRE = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0;
   logic [CW-1:0] dm_code = '0;
   logic [LW-1:0] t1_len = 4'd1;
   logic [LW-1:0] t2_len = 4'd1;
   logic cmp_low;
   logic idle = 1'b0;
   logic [WW-1:0] wake_len = '0;
   logic sw_pre, sw_chg, sw_dis, searching, opt_valid, pwr_off, out_valid;
   logic [CW-1:0] cand_code, opt_code, reg_code;

   logic [CW-1:0] m_opt = '0;
   logic m_never = 1'b0;
   assign cmp_low = m_never ? 1'b0 : (cand_code <= m_opt);

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   mep_supply_ctrl #(.CODE_W(CW), .LEN_W(LW), .WAKE_W(WW), .PRE_CYC(PRE)) u_mep_supply_ctrl (
      .clk(clk), .rst_n(rst_n), .restart(restart), .dm_code(dm_code),
      .t1_len(t1_len), .t2_len(t2_len), .cmp_low(cmp_low), .idle(idle),
      .wake_len(wake_len), .sw_pre(sw_pre), .sw_chg(sw_chg), .sw_dis(sw_dis),
      .cand_code(cand_code), .searching(searching), .opt_code(opt_code),
      .opt_valid(opt_valid), .reg_code(reg_code), .pwr_off(pwr_off),
      .out_valid(out_valid));

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // vector: dm[21:16] model[15:10] never[9] t1[8:5] t2[4:1] mid_restart[0]
   localparam int NV = 6;
   localparam logic [21:0] VEC [NV] = '{
      {6'd40, 6'd35, 1'b0, 4'd3, 4'd2, 1'b0},
      {6'd20, 6'd30, 1'b0, 4'd2, 4'd3, 1'b1},
      {6'd10, 6'd45, 1'b0, 4'd1, 4'd1, 1'b0},
      {6'd50, 6'd44, 1'b0, 4'd0, 4'd5, 1'b0},
      {6'd5,  6'd0,  1'b1, 4'd1, 4'd0, 1'b0},
      {6'd12, 6'd8,  1'b0, 4'd4, 4'd4, 1'b0}
   };

   int cur_opt = 0;
   bit cur_valid = 0;

   task automatic run_search(input bit mid, output int chg_n, output int dis_n,
                             output int first_cand, output int multi_on);
      int guard;
      chg_n = 0; dis_n = 0; multi_on = 0; guard = 0;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      first_cand = cand_code;
      while (searching && guard < 20000) begin
         if (sw_chg) chg_n++;
         if (sw_dis) dis_n++;
         if ((32'(sw_pre) + 32'(sw_chg) + 32'(sw_dis)) > 1) multi_on++;
         guard++;
         if (mid && guard == 7) restart = 1'b1;
         @(negedge clk);
         restart = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int chg_n, dis_n, fc, mo, start, exp_opt, meas, cnt;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 switches", 32'(sw_pre | sw_chg | sw_dis), 0);
      chk("R10 searching/opt_valid", 32'(searching | opt_valid), 0);
      chk("R10 opt_code", opt_code, 0);
      chk("R10 pwr_off", pwr_off, 0);
      chk("R10 out_valid", out_valid, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reg_code", reg_code, 0);
      // R6: before any search the request passes through
      dm_code = 6'd17;
      @(negedge clk);
      chk("R6 no floor yet", reg_code, 17);

      for (int v = 0; v < NV; v++) begin
         dm_code = VEC[v][21:16];
         m_opt   = VEC[v][15:10];
         m_never = VEC[v][9];
         t1_len  = VEC[v][8:5];
         t2_len  = VEC[v][4:1];
         @(negedge clk);
         @(negedge clk);
         start = (cur_valid && cur_opt > int'(dm_code)) ? cur_opt : int'(dm_code);
         chk("R6 pre-search reg", reg_code, start);
         exp_opt = m_never ? 0 : ((int'(m_opt) < start) ? int'(m_opt) : start);
         meas = start - exp_opt + 1;
         run_search(VEC[v][0], chg_n, dis_n, fc, mo);
         chk("R1 first candidate", fc, start);
         chk("R2 single switch", mo, 0);
         chk("R3 charge cycles", chg_n, meas * ((t1_len == 0) ? 1 : int'(t1_len)));
         chk("R3 discharge cycles", dis_n, meas * ((t2_len == 0) ? 1 : int'(t2_len)));
         chk(m_never ? "R5 floor at zero" : "R4 optimum", opt_code, exp_opt);
         chk("R4 opt_valid", opt_valid, 1);
         cur_opt = exp_opt; cur_valid = 1;
         @(negedge clk);
         chk("R6 post-search reg",
             reg_code, (cur_opt > int'(dm_code)) ? cur_opt : int'(dm_code));
      end

      // optimum is now 8
      dm_code = 6'd3;
      @(negedge clk);
      chk("R6 request below optimum", reg_code, 8);
      dm_code = 6'd21;
      @(negedge clk);
      chk("R6 request above optimum", reg_code, 21);
      // R7: not at optimum -> idle ignored
      idle = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R7 no gating above optimum", pwr_off, 0);
      chk("R7 output stays valid", out_valid, 1);
      idle = 1'b0;
      dm_code = 6'd8;
      @(negedge clk); @(negedge clk);
      idle = 1'b1;
      #1 chk("R7 not yet off", pwr_off, 0);
      @(negedge clk);
      chk("R7 gated at optimum", pwr_off, 1);
      // R8: wake-up with count 3
      wake_len = 4'd3;
      @(negedge clk);
      idle = 1'b0;
      #1 chk("R8 power back at once", pwr_off, 0);
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!out_valid && cnt < 50);
      chk("R8 wake delay 3", cnt, 4);
      // R8: wake-up with count 0
      wake_len = 4'd0;
      idle = 1'b1;
      @(negedge clk); @(negedge clk);
      idle = 1'b0;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!out_valid && cnt < 50);
      chk("R8 wake delay 0", cnt, 1);

      // R9: request changes during a search reach the regulator
      m_opt = 6'd2; m_never = 1'b0; t1_len = 4'd2; t2_len = 4'd2;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      repeat (3) @(negedge clk);
      dm_code = 6'd33;
      @(negedge clk);
      chk("R9 searching", searching, 1);
      chk("R9 reg follows request", reg_code, 33);
      cnt = 0;
      while (searching && cnt < 5000) begin @(negedge clk); cnt++; end
      chk("R9 optimum from start 8", opt_code, 2);
      @(negedge clk);
      chk("R9 reg after search", reg_code, 33);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule